// File: doc/BRIEF.md
# Quad-SPI Flash Identification Probe

This block works out which serial flash device sits on a quad-SPI port. It runs up to three read-identifier transactions in a fixed order. Each uses a different lane protocol and opcode. It stops at the first transaction that returns a plausible manufacturer byte. A one-cycle `start` pulse launches the probe. When it finishes, the block reports the manufacturer byte, the two device bytes, a code naming the successful step, and either a `done` or a `fail` flag. These results hold until the next start.

The block drives SCK, an active-low chip select, and four data lines, each with its own output enable. SCK comes from the system clock through a simple divider of `DIV_HALF` clock cycles per half period. SCK idles low. The block launches data on falling SCK edges and samples on rising SCK edges.

The controller has five named states:
- IDLE waits for `start`.
- GAP holds chip select high for two SCK periods.
- OPCODE shifts the opcode out.
- RESP captures three response bytes.
- CHECK validates the manufacturer byte.

The transitions are:
- IDLE→GAP on start.
- GAP→OPCODE when the gap count expires.
- OPCODE→RESP on the falling edge after the last opcode clock.
- RESP→CHECK on the falling edge after the last response clock.
- CHECK→IDLE on a valid ID or after the third attempt.
- CHECK→GAP otherwise.

Top module: `qspi_id_probe`

## Requirements
- R1: After reset and whenever idle, `busy`, `done` and `fail` are 0 and `cs_n` is 1. A `start` pulse while idle sets `busy` in the next cycle and clears `done` and `fail`.
- R2: Attempt 1 has two phases. First come 8 SCK clocks carrying 9Fh MSB first on IO0, with only `io_oe[0]` set. Then come 24 clocks that sample IO1 only. That is 32 rising SCK edges with chip select low.
- R3: Attempt 2 has two phases. First, AFh goes out MSB first on IO0 over 8 clocks. Then 6 clocks sample all four lines as nibbles, with IO3 as the nibble MSB and the high nibble first. That is 14 rising edges in total.
- R4: Attempt 3 has two phases. First, AFh goes out on IO3..IO0 in 2 clocks, high nibble first, with all four enables set. Then come 6 quad response clocks. That is 8 rising edges in total.
- R5: The attempts always run in the order 1, 2, 3. The next attempt runs only when the current one captures a manufacturer byte of 00h or FFh. A valid capture ends the probe with no further transaction.
- R6: If all three attempts are invalid, the block sets `fail`=1 and `done`=0. It also sets `step_code`, `mfr_id` and `dev_id` to 0.
- R7: On a valid capture, the block sets `done`=1. `mfr_id` is the first byte received, and `dev_id` is {second byte, third byte}. `step_code` is 1, 2 or 3 for the attempt that succeeded.
- R8: Before each attempt, `cs_n` stays high for at least 4*`DIV_HALF` clock cycles, which is two SCK periods.
- R9: `io_out` and `io_oe` change only together with a falling SCK edge. The enables drop on the falling edge that follows the last opcode clock. Response bits are sampled on rising edges.
- R10: `done`, `fail`, `mfr_id`, `dev_id` and `step_code` hold their values until the next `start`. A `start` while `busy` is ignored.
- R11: Whenever `cs_n` is high, `sck` is low and `io_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a probe |
| sck | output | 1 | Serial clock to the flash, idle low |
| cs_n | output | 1 | Active-low chip select |
| io_out | output | 4 | Values driven onto IO3..IO0 |
| io_oe | output | 4 | Per-line output enables for IO3..IO0 |
| io_in | input | 4 | Values read back from IO3..IO0 |
| busy | output | 1 | Probe in progress |
| done | output | 1 | A valid identifier was captured |
| fail | output | 1 | All three attempts were invalid |
| mfr_id | output | 8 | Captured manufacturer byte |
| dev_id | output | 16 | Captured device bytes, first received in bits 15:8 |
| step_code | output | 2 | 0 none, 1 single-lane, 2 mixed, 3 all-quad |

## Verification
A behavioural flash model is attached to the data lines, and each model variant answers exactly one of the three opcode and lane combinations. A device that answers only the single-lane 9Fh command, only the serial-opcode AFh command with quad reply, or only the all-quad AFh command tells apart the three steps and the order they run in. Two further cases check validation and the stop-on-success rule:
- An absent device leaves the lines pulled high.
- A device that answers with 00h or FFh as its manufacturer byte forces the full fallback chain into the fail flag.

Per-transaction records of the rising-edge count, the opcode seen serially and in quad form, and the enables at the first and last edge separate the opcode phase from the response phase of each step.

// File: rtl/qprobe_pkg.sv
package qprobe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_OPCODE,
        ST_RESP,
        ST_CHECK
    } probe_state_t;

    typedef struct packed {
        logic [7:0] opcode;
        logic       quad_cmd;
        logic       quad_rsp;
    } attempt_cfg_t;

    localparam int N_ATTEMPTS = 3;
    localparam int OP_BITS    = 8;
    localparam int ID_BYTES   = 3;
    localparam int ID_BITS    = ID_BYTES * 8;
    localparam int MISO_LANE  = 1;

    function automatic attempt_cfg_t attempt_cfg(input logic [1:0] idx);
        attempt_cfg_t c;
        unique case (idx)
            2'd0:    c = '{opcode: 8'h9F, quad_cmd: 1'b0, quad_rsp: 1'b0};
            2'd1:    c = '{opcode: 8'hAF, quad_cmd: 1'b0, quad_rsp: 1'b1};
            default: c = '{opcode: 8'hAF, quad_cmd: 1'b1, quad_rsp: 1'b1};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/qprobe_sck_div.sv
module qprobe_sck_div #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sck,
    output logic rise,
    output logic fall
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

    logic [CW-1:0] cnt_q;
    logic          sck_q;
    logic          tick;

    assign tick = run && (cnt_q == CW'(DIV_HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sck_q <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            sck_q <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            sck_q <= ~sck_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign sck  = sck_q;
    assign rise = tick & ~sck_q;
    assign fall = tick & sck_q;
endmodule

// File: rtl/qprobe_tx_shift.sv
module qprobe_tx_shift #(
    parameter int OP_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [OP_W-1:0] opcode,
    input  logic            quad,
    input  logic            shift,
    output logic [3:0]      io_out
);
    logic [OP_W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= opcode;
        end else if (shift) begin
            if (quad) sh_q <= {sh_q[OP_W-5:0], 4'b0000};
            else      sh_q <= {sh_q[OP_W-2:0], 1'b0};
        end
    end

    assign io_out = quad ? sh_q[OP_W-1 -: 4] : {3'b000, sh_q[OP_W-1]};
endmodule

// File: rtl/qprobe_rx_capture.sv
module qprobe_rx_capture #(
    parameter int ID_W  = 24,
    parameter int SLANE = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            sample,
    input  logic            quad,
    input  logic [3:0]      io_in,
    output logic [ID_W-1:0] id_word
);
    logic [ID_W-1:0] id_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_q <= '0;
        end else if (clear) begin
            id_q <= '0;
        end else if (sample) begin
            if (quad) id_q <= {id_q[ID_W-5:0], io_in};
            else      id_q <= {id_q[ID_W-2:0], io_in[SLANE]};
        end
    end

    assign id_word = id_q;
endmodule

// File: rtl/qspi_id_probe.sv
module qspi_id_probe
    import qprobe_pkg::*;
#(
    parameter int DIV_HALF = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output logic        sck,
    output logic        cs_n,
    output logic [3:0]  io_out,
    output logic [3:0]  io_oe,
    input  logic [3:0]  io_in,
    output logic        busy,
    output logic        done,
    output logic        fail,
    output logic [7:0]  mfr_id,
    output logic [15:0] dev_id,
    output logic [1:0]  step_code
);
    localparam int GAP_CYC = 4 * DIV_HALF;
    localparam int GAP_W   = $clog2(GAP_CYC + 1);
    localparam int CNT_W   = $clog2(ID_BITS + 1);

    probe_state_t state_q, state_d;
    attempt_cfg_t cfg;

    logic [1:0]         attempt_q;
    logic [GAP_W-1:0]   gap_q;
    logic [CNT_W-1:0]   clk_cnt_q;
    logic [CNT_W-1:0]   op_clks, rsp_clks;
    logic               sck_rise, sck_fall, run;
    logic               gap_done, last_op, last_rsp, last_attempt, id_ok;
    logic               load_op, sample_rsp, shift_op;
    logic [ID_BITS-1:0] id_word;
    logic [7:0]         mfr_cap;

    logic        done_q, fail_q;
    logic [7:0]  mfr_q;
    logic [15:0] dev_q;
    logic [1:0]  code_q;

    assign cfg          = attempt_cfg(attempt_q);
    assign op_clks      = cfg.quad_cmd ? CNT_W'(OP_BITS / 4) : CNT_W'(OP_BITS);
    assign rsp_clks     = cfg.quad_rsp ? CNT_W'(ID_BITS / 4) : CNT_W'(ID_BITS);
    assign gap_done     = (gap_q == GAP_W'(GAP_CYC - 1));
    assign last_op      = (clk_cnt_q == op_clks);
    assign last_rsp     = (clk_cnt_q == rsp_clks);
    assign last_attempt = (attempt_q == 2'(N_ATTEMPTS - 1));
    assign mfr_cap      = id_word[ID_BITS-1 -: 8];
    assign id_ok        = (mfr_cap != 8'h00) && (mfr_cap != 8'hFF);
    assign run          = (state_q == ST_OPCODE) || (state_q == ST_RESP);
    assign load_op      = (state_q == ST_GAP) && gap_done;
    assign shift_op     = (state_q == ST_OPCODE) && sck_fall;
    assign sample_rsp   = (state_q == ST_RESP) && sck_rise;

    qprobe_sck_div #(.DIV_HALF(DIV_HALF)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .sck  (sck),
        .rise (sck_rise),
        .fall (sck_fall)
    );

    qprobe_tx_shift #(.OP_W(OP_BITS)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_op),
        .opcode(cfg.opcode),
        .quad  (cfg.quad_cmd),
        .shift (shift_op),
        .io_out(io_out)
    );

    qprobe_rx_capture #(.ID_W(ID_BITS), .SLANE(MISO_LANE)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (load_op),
        .sample (sample_rsp),
        .quad   (cfg.quad_rsp),
        .io_in  (io_in),
        .id_word(id_word)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_GAP;
            ST_GAP:    if (gap_done) state_d = ST_OPCODE;
            ST_OPCODE: if (sck_fall && last_op) state_d = ST_RESP;
            ST_RESP:   if (sck_fall && last_rsp) state_d = ST_CHECK;
            ST_CHECK:  state_d = (id_ok || last_attempt) ? ST_IDLE : ST_GAP;
            default:   state_d = ST_IDLE;
        endcase
    end

    // counters, attempt index and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            attempt_q <= '0;
            gap_q     <= '0;
            clk_cnt_q <= '0;
            done_q    <= 1'b0;
            fail_q    <= 1'b0;
            mfr_q     <= '0;
            dev_q     <= '0;
            code_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        attempt_q <= '0;
                        gap_q     <= '0;
                        done_q    <= 1'b0;
                        fail_q    <= 1'b0;
                        mfr_q     <= '0;
                        dev_q     <= '0;
                        code_q    <= '0;
                    end
                end
                ST_GAP: begin
                    gap_q     <= gap_q + 1'b1;
                    clk_cnt_q <= '0;
                end
                ST_OPCODE: begin
                    if (sck_rise)                  clk_cnt_q <= clk_cnt_q + 1'b1;
                    else if (sck_fall && last_op)  clk_cnt_q <= '0;
                end
                ST_RESP: begin
                    if (sck_rise) clk_cnt_q <= clk_cnt_q + 1'b1;
                end
                ST_CHECK: begin
                    gap_q <= '0;
                    if (id_ok) begin
                        done_q <= 1'b1;
                        mfr_q  <= mfr_cap;
                        dev_q  <= id_word[15:0];
                        code_q <= attempt_q + 2'd1;
                    end else if (last_attempt) begin
                        fail_q <= 1'b1;
                    end else begin
                        attempt_q <= attempt_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // pin outputs
    always_comb begin
        cs_n  = !run;
        busy  = (state_q != ST_IDLE);
        io_oe = 4'b0000;
        if (state_q == ST_OPCODE) io_oe = cfg.quad_cmd ? 4'b1111 : 4'b0001;
    end

    assign done      = done_q;
    assign fail      = fail_q;
    assign mfr_id    = mfr_q;
    assign dev_id    = dev_q;
    assign step_code = code_q;
endmodule

// File: rtl/qprobe_checker.sv
module qprobe_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        sck,
    input logic        cs_n,
    input logic [3:0]  io_out,
    input logic [3:0]  io_oe,
    input logic        busy,
    input logic        done,
    input logic        fail,
    input logic [7:0]  mfr_id,
    input logic [15:0] dev_id,
    input logic [1:0]  step_code
);
    p_cs_sck_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    p_cs_oe_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (io_oe == 4'b0000));

    p_oe_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !$past(cs_n) && (io_oe != $past(io_oe))) |-> (!sck && $past(sck)));

    p_out_hold_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && sck && $past(sck)) |-> (io_out == $past(io_out)));

    p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

    p_fail_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (step_code == 2'd0 && mfr_id == 8'h00 && dev_id == 16'h0000));

    p_done_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mfr_id != 8'h00 && mfr_id != 8'hFF && step_code != 2'd0));

    p_busy_flags_r1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!done && !fail));

    p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(mfr_id) && $stable(dev_id) && $stable(step_code)
                               && $stable(done) && $stable(fail)));
endmodule

bind qspi_id_probe qprobe_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .sck      (sck),
    .cs_n     (cs_n),
    .io_out   (io_out),
    .io_oe    (io_oe),
    .busy     (busy),
    .done     (done),
    .fail     (fail),
    .mfr_id   (mfr_id),
    .dev_id   (dev_id),
    .step_code(step_code)
);

// File: tb/qspi_id_probe_tb_top.sv
module qspi_id_probe_tb_top;
    localparam int DIV_HALF = 2;
    localparam int LIMIT    = 3000;

    typedef struct packed {
        logic [3:0]  kind;
        logic [23:0] id;
        logic [1:0]  code;
        logic        fl;
        logic [7:0]  mfr;
        logic [15:0] dev;
    } vec_t;

    // kind: 0 absent, 1 answers 9Fh single lane, 2 answers AFh serial opcode + quad reply,
    // 3 answers AFh on four lanes only
    localparam vec_t VECS [8] = '{
        '{4'd1, 24'hC22018, 2'd1, 1'b0, 8'hC2, 16'h2018},
        '{4'd2, 24'h20BA19, 2'd2, 1'b0, 8'h20, 16'hBA19},
        '{4'd3, 24'h20BB21, 2'd3, 1'b0, 8'h20, 16'hBB21},
        '{4'd0, 24'h000000, 2'd0, 1'b1, 8'h00, 16'h0000},
        '{4'd1, 24'h001234, 2'd0, 1'b1, 8'h00, 16'h0000},
        '{4'd2, 24'hFF5566, 2'd0, 1'b1, 8'h00, 16'h0000},
        '{4'd3, 24'h018000, 2'd3, 1'b0, 8'h01, 16'h8000},
        '{4'd1, 24'hEF4018, 2'd1, 1'b0, 8'hEF, 16'h4018}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        sck, cs_n, busy, done, fail;
    logic [3:0]  io_out, io_oe, io_in;
    logic [7:0]  mfr_id;
    logic [15:0] dev_id;
    logic [1:0]  step_code;

    int n_checks = 0;
    int n_err    = 0;

    always #5 clk = ~clk;

    qspi_id_probe #(.DIV_HALF(DIV_HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .sck(sck), .cs_n(cs_n),
        .io_out(io_out), .io_oe(io_oe), .io_in(io_in), .busy(busy), .done(done),
        .fail(fail), .mfr_id(mfr_id), .dev_id(dev_id), .step_code(step_code)
    );

    // ---------------- flash model ----------------
    int          fl_kind = 0;
    logic [23:0] fl_id   = '0;
    logic [3:0]  fl_out  = '0;
    logic [3:0]  fl_oe   = '0;
    int          n_rise  = 0;
    int          rsp_idx = 0;
    int          win_cnt = 0;
    logic [7:0]  ser_b   = '0;
    logic [7:0]  quad_b  = '0;
    logic [3:0]  oe_first = '0;
    logic [3:0]  oe_last  = '0;
    bit          act = 0;
    bit          act_quad = 0;
    int          rec_rise [16];
    logic [7:0]  rec_ser  [16];
    logic [7:0]  rec_quad [16];
    logic [3:0]  rec_oe_f [16];
    logic [3:0]  rec_oe_l [16];

    assign io_in = (io_oe & io_out) | (~io_oe & fl_oe & fl_out) | (~io_oe & ~fl_oe);

    always @(posedge sck or negedge sck or posedge cs_n) begin
        if (cs_n) begin
            rec_rise[win_cnt % 16] = n_rise;
            rec_ser[win_cnt % 16]  = ser_b;
            rec_quad[win_cnt % 16] = quad_b;
            rec_oe_f[win_cnt % 16] = oe_first;
            rec_oe_l[win_cnt % 16] = oe_last;
            win_cnt++;
            n_rise = 0; rsp_idx = 0; ser_b = '0; quad_b = '0;
            act = 0; act_quad = 0; fl_oe = '0; fl_out = '0;
        end else if (sck) begin
            if (n_rise == 0) oe_first = io_oe;
            oe_last = io_oe;
            if (n_rise < 8) ser_b  = {ser_b[6:0], io_in[0]};
            if (n_rise < 2) quad_b = {quad_b[3:0], io_in};
            n_rise++;
            if (fl_kind == 1 && n_rise == 8 && ser_b == 8'h9F)  begin act = 1; act_quad = 0; end
            if (fl_kind == 2 && n_rise == 8 && ser_b == 8'hAF)  begin act = 1; act_quad = 1; end
            if (fl_kind == 3 && n_rise == 2 && quad_b == 8'hAF) begin act = 1; act_quad = 1; end
        end else if (act) begin
            if (act_quad) begin
                fl_oe  = 4'hF;
                fl_out = (rsp_idx < 6) ? fl_id[23 - 4*rsp_idx -: 4] : 4'h0;
            end else begin
                fl_oe  = 4'b0010;
                fl_out = {2'b00, (rsp_idx < 24) ? fl_id[23 - rsp_idx] : 1'b0, 1'b0};
            end
            rsp_idx++;
        end
    end

    // shortest chip-select-high stretch seen
    int hi_run  = 0;
    int min_gap = 1000000;
    always @(posedge clk) begin
        if (cs_n) hi_run++;
        else begin
            if (hi_run > 0 && hi_run < min_gap) min_gap = hi_run;
            hi_run = 0;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input string what, input logic [31:0] act_v,
                       input logic [31:0] exp_v);
        n_checks++;
        if (act_v !== exp_v) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act_v, exp_v);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_end();
        int c = 0;
        while (!(done || fail) && c < LIMIT) begin
            @(negedge clk);
            c++;
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int base;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R11: reset and idle state
        chk("R1", "busy at reset", busy, 0);
        chk("R1", "done/fail at reset", {done, fail}, 0);
        chk("R11", "cs_n/sck at reset", {cs_n, sck}, 2'b10);
        chk("R11", "io_oe at reset", io_oe, 0);

        // vector table; a correct capture in each case depends on R9 edge timing
        for (int i = 0; i < 8; i++) begin
            fl_kind = int'(VECS[i].kind);
            fl_id   = VECS[i].id;
            base    = win_cnt;
            pulse_start();
            chk("R1", "busy after start", busy, 1);
            wait_end();
            @(negedge clk);
            if (VECS[i].fl) begin
                chk("R6", "done/fail", {done, fail}, 2'b01);
                chk("R6", "mfr/dev", {mfr_id, dev_id}, 0);
                chk("R6", "step_code", step_code, 0);
                chk("R5", "transactions on fail", win_cnt - base, 3);
            end else begin
                chk("R7", "done/fail", {done, fail}, 2'b10);
                chk("R7", "mfr_id", mfr_id, VECS[i].mfr);
                chk("R7", "dev_id", dev_id, VECS[i].dev);
                chk("R7", "step_code", step_code, VECS[i].code);
                chk("R5", "transactions until success", win_cnt - base, VECS[i].code);
            end
            chk("R11", "idle lines", {cs_n, sck, io_oe}, 6'b100000);
        end

        // R10: results hold while idle
        fl_kind = 1; fl_id = 24'hC84017;
        pulse_start();
        wait_end();
        @(negedge clk);
        fl_kind = 0;
        repeat (60) @(negedge clk);
        chk("R10", "held result", {done, fail, step_code, mfr_id, dev_id}, {1'b1, 1'b0, 2'd1, 24'hC84017});

        // R10: start during a probe is ignored
        fl_kind = 2; fl_id = 24'h9D6016;
        base = win_cnt;
        pulse_start();
        repeat (30) @(negedge clk);
        pulse_start();
        wait_end();
        @(negedge clk);
        chk("R10", "result with extra start", {done, step_code, mfr_id, dev_id}, {1'b1, 2'd2, 24'h9D6016});
        chk("R10", "transactions with extra start", win_cnt - base, 2);

        // R2 R3 R4 R8 R9: transaction shapes with no device attached
        fl_kind = 0;
        base = win_cnt;
        pulse_start();
        wait_end();
        @(negedge clk);
        chk("R2", "edges attempt 1", rec_rise[base % 16], 32);
        chk("R2", "serial opcode attempt 1", rec_ser[base % 16], 8'h9F);
        chk("R2", "enables at first edge 1", rec_oe_f[base % 16], 4'b0001);
        chk("R3", "edges attempt 2", rec_rise[(base + 1) % 16], 14);
        chk("R3", "serial opcode attempt 2", rec_ser[(base + 1) % 16], 8'hAF);
        chk("R3", "enables at first edge 2", rec_oe_f[(base + 1) % 16], 4'b0001);
        chk("R4", "edges attempt 3", rec_rise[(base + 2) % 16], 8);
        chk("R4", "quad opcode attempt 3", rec_quad[(base + 2) % 16], 8'hAF);
        chk("R4", "enables at first edge 3", rec_oe_f[(base + 2) % 16], 4'b1111);
        for (int w = 0; w < 3; w++)
            chk("R9", "enables released by last edge", rec_oe_l[(base + w) % 16], 4'b0000);
        chk("R8", "min cs_n high stretch ok", (min_gap >= 4 * DIV_HALF) ? 1 : 0, 1);

        finish_run();
    end
endmodule